// File: doc/BRIEF.md
# Watermarked Card Data FIFO

This block is the word-wide data buffer between a host bus (or a DMA engine) and the data path of a memory-card controller. The host side reaches the FIFO through a small register port. One data register pushes a word on write and pops a word on read. The card side has its own push and pop strobes. Two watermark levels, set in a threshold register, drive two interrupt requests. The receive-ready request tells the host to drain the FIFO. The transmit-ready request tells it to refill.

The threshold register comes out of reset with its receive watermark set to the FIFO depth minus one, so software can learn the depth by reading it. A status register reports the fill level together with empty and full flags. A flush bit in the control register empties the FIFO and then clears itself, so software polls it until it reads zero. Any access that cannot be served is dropped and latched as an error in the raw interrupt register: a push into a full FIFO, or a pop from an empty one. Bits of the raw interrupt register are cleared by writing ones to them.

Top module: `card_data_fifo`

## Requirements
- R1: Right after reset, the status register (address 2) reads empty=1, full=0 and fill count 0. The threshold register (address 1) reads a receive watermark of DEPTH-1, with the transmit watermark and the burst field both 0.
- R2: Words leave the FIFO in the order they entered it. This holds for host data-register writes (address 4) drained by card pops, and for card pushes drained by host data-register reads.
- R3: The status register carries empty in bit 0, full in bit 1 and the fill count in bits starting at bit 16. All other bits read as zero.
- R4: A push while the FIFO is full is discarded and sets the overrun bit (bit 2) of the raw interrupt register (address 3). The stored contents stay unchanged.
- R5: A pop while the FIFO is empty returns zero, leaves the FIFO unchanged and sets the underrun bit (bit 3) of the raw interrupt register.
- R6: Writing 1 to bit 0 of the control register (address 0) makes that bit read 1 for exactly one cycle. The FIFO is then empty and the bit reads 0.
- R7: The receive-ready bit (raw bit 0, also the irq_rx_ready output) becomes set when the fill count is strictly greater than the receive watermark (threshold bits 23:16).
- R8: The transmit-ready bit (raw bit 1, also the irq_tx_ready output) becomes set when the fill count is less than or equal to the transmit watermark (threshold bits 7:0).
- R9: Writing ones to the raw interrupt register clears those bits. A bit whose set condition still holds in that cycle stays set. Once set, a ready bit stays set until it is cleared, even after its condition goes away.
- R10: The threshold register stores a burst field in bits 30:28, the receive watermark in bits 23:16 and the transmit watermark in bits 7:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when addressing the data register) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from the address |
| card_push | input | 1 | Card side pushes card_wdata |
| card_wdata | input | DATA_W | Word from the card path |
| card_pop | input | 1 | Card side pops the head word |
| card_rdata | output | DATA_W | Head word for the card path, zero when empty |
| irq_rx_ready | output | 1 | Receive-ready request |
| irq_tx_ready | output | 1 | Transmit-ready request |

## Verification
The bench fills the FIFO to exactly DEPTH and then pushes once more. A design that wraps its pointers would overwrite the oldest word, and the read-back order would reveal it. It reads once more after draining the FIFO. A design that did not block that pop would return stale data and corrupt the fill count. The watermarks are placed so that off-by-one comparisons show up: receive-ready must stay clear at a count equal to the mark. Write-one-to-clear is issued both while the condition still holds and after it has gone away. This catches a bit that never re-asserts, and a bit that behaves as a plain level instead of a latched one. The flush bit is read in the cycle after the write and in the cycle after that. A flag that never self-clears, or a flush that leaves words behind, fails there.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
    localparam int MARK_W = 8;
    localparam int BURST_W = 3;

    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_THRESH = 3'd1;
    localparam logic [2:0] ADR_STATUS = 3'd2;
    localparam logic [2:0] ADR_RAWINT = 3'd3;
    localparam logic [2:0] ADR_DATA   = 3'd4;

    localparam int TX_LSB    = 0;
    localparam int RX_LSB    = 16;
    localparam int BURST_LSB = 28;
    localparam int CNT_LSB   = 16;

    // raw interrupt bit positions
    localparam int EV_RX  = 0;
    localparam int EV_TX  = 1;
    localparam int EV_OVR = 2;
    localparam int EV_UND = 3;
    localparam int EV_N   = 4;
endpackage

// File: rtl/cdf_ring.sv
module cdf_ring #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              push_drop,
    output logic              pop_drop
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t s_q, s_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty     = (s_q.cnt == '0);
    assign full      = (s_q.cnt == CNT_W'(DEPTH));
    assign push_ok   = push && !full && !flush;
    assign pop_ok    = pop && !empty && !flush;
    assign push_drop = push && full && !flush;
    assign pop_drop  = pop && empty && !flush;
    assign head      = empty ? '0 : mem_q[s_q.rd];
    assign count     = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wr = s_q.wr + 1'b1;
            if (pop_ok)  s_d.rd = s_q.rd + 1'b1;
            s_d.cnt = s_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr] <= push_data;
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(s_q.cnt));

    // R5
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (s_q.cnt == '0));
endmodule

// File: rtl/cdf_events.sv
module cdf_events
    import cdf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic [MARK_W-1:0] rx_mark,
    input  logic [MARK_W-1:0] tx_mark,
    input  logic              push_drop,
    input  logic              pop_drop,
    input  logic [EV_N-1:0]   clr,
    output logic [EV_N-1:0]   raw
);
    typedef struct packed {
        logic [EV_N-1:0] raw;
    } ev_t;

    ev_t s_q, s_d;
    logic [MARK_W-1:0] lvl;
    logic [EV_N-1:0] set;

    assign lvl = MARK_W'(count);

    always_comb begin
        set          = '0;
        set[EV_RX]   = lvl > rx_mark;
        set[EV_TX]   = lvl <= tx_mark;
        set[EV_OVR]  = push_drop;
        set[EV_UND]  = pop_drop;
        s_d.raw      = (s_q.raw & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw = s_q.raw;

    // R4
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_drop |=> raw[EV_OVR]);

    // R5
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_drop |=> raw[EV_UND]);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[EV_RX] && !clr[EV_RX]) |=> raw[EV_RX]);
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
    import cdf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    output logic [DATA_W-1:0] card_rdata,
    output logic              irq_rx_ready,
    output logic              irq_tx_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic               flush;
        logic [BURST_W-1:0] burst;
        logic [MARK_W-1:0]  rx_mark;
        logic [MARK_W-1:0]  tx_mark;
    } ctl_t;

    ctl_t c_q, c_d;
    logic host_push, host_pop, push, pop;
    logic [DATA_W-1:0] push_data, head;
    logic [CNT_W-1:0] count;
    logic empty, full, push_drop, pop_drop;
    logic [EV_N-1:0] clr, raw;

    assign host_push = reg_wr && (reg_addr == ADR_DATA);
    assign host_pop  = reg_rd && (reg_addr == ADR_DATA);
    assign push      = host_push || card_push;
    assign pop       = host_pop || card_pop;
    assign push_data = host_push ? reg_wdata : card_wdata;
    assign clr       = (reg_wr && reg_addr == ADR_RAWINT) ? reg_wdata[EV_N-1:0] : '0;

    always_comb begin
        c_d = c_q;
        c_d.flush = 1'b0;
        if (reg_wr && reg_addr == ADR_CTRL && reg_wdata[0]) c_d.flush = 1'b1;
        if (reg_wr && reg_addr == ADR_THRESH) begin
            c_d.burst   = reg_wdata[BURST_LSB +: BURST_W];
            c_d.rx_mark = reg_wdata[RX_LSB +: MARK_W];
            c_d.tx_mark = reg_wdata[TX_LSB +: MARK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.rx_mark <= MARK_W'(DEPTH - 1);
        end else begin
            c_q <= c_d;
        end
    end

    cdf_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(c_q.flush),
        .push(push), .push_data(push_data), .pop(pop),
        .head(head), .count(count), .empty(empty), .full(full),
        .push_drop(push_drop), .pop_drop(pop_drop)
    );

    cdf_events #(.CNT_W(CNT_W)) u_events (
        .clk(clk), .rst_n(rst_n), .count(count),
        .rx_mark(c_q.rx_mark), .tx_mark(c_q.tx_mark),
        .push_drop(push_drop), .pop_drop(pop_drop),
        .clr(clr), .raw(raw)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL:   reg_rdata[0] = c_q.flush;
            ADR_THRESH: begin
                reg_rdata[BURST_LSB +: BURST_W] = c_q.burst;
                reg_rdata[RX_LSB +: MARK_W]     = c_q.rx_mark;
                reg_rdata[TX_LSB +: MARK_W]     = c_q.tx_mark;
            end
            ADR_STATUS: begin
                reg_rdata[0]               = empty;
                reg_rdata[1]               = full;
                reg_rdata[CNT_LSB +: CNT_W] = count;
            end
            ADR_RAWINT: reg_rdata[EV_N-1:0] = raw;
            ADR_DATA:   reg_rdata = head;
            default:    reg_rdata = '0;
        endcase
    end

    assign card_rdata   = head;
    assign irq_rx_ready = raw[EV_RX];
    assign irq_tx_ready = raw[EV_TX];

    // R6
    flush_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.flush |=> !c_q.flush);

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.flush |=> empty);
endmodule

// File: tb/card_data_fifo_test.sv
module card_data_fifo_test;
    localparam int DW = 32;
    localparam int DEPTH = 16;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [DW-1:0] reg_wdata = 0, reg_rdata;
    logic card_push = 0, card_pop = 0;
    logic [DW-1:0] card_wdata = 0, card_rdata;
    logic irq_rx_ready, irq_tx_ready;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    card_data_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(3'd2, v); check("R1 status", v, 32'h1);
        rd(3'd1, v); check("R1 thresh", v, 32'(DEPTH - 1) << 16);
    endtask

    task automatic t_order();
        logic [DW-1:0] v;
        for (int i = 0; i < 5; i++) wr(3'd4, 32'hA000 + i);
        rd(3'd2, v); check("R3 count5", v, 32'h0005_0000);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); card_pop = 1; #1 check("R2 card pop", card_rdata, 32'hA000 + i);
            @(negedge clk); card_pop = 0;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); card_push = 1; card_wdata = 32'hC0DE0 + i;
            @(negedge clk); card_push = 0;
        end
        for (int i = 0; i < 3; i++) begin
            rd(3'd4, v); check("R2 host read", v, 32'hC0DE0 + i);
        end
    endtask

    task automatic t_full();
        logic [DW-1:0] v;
        wr(3'd3, 32'hF);
        for (int i = 0; i < DEPTH; i++) wr(3'd4, 32'h100 + i);
        rd(3'd2, v); check("R3 full status", v, (32'(DEPTH) << 16) | 32'h2);
        wr(3'd4, 32'hDEAD);
        idle(1);
        rd(3'd3, v); check("R4 overrun bit", v & 32'h4, 32'h4);
        rd(3'd2, v); check("R4 count kept", v, (32'(DEPTH) << 16) | 32'h2);
        for (int i = 0; i < DEPTH; i++) begin
            rd(3'd4, v); check("R4 contents", v, 32'h100 + i);
        end
        wr(3'd3, 32'hF);
        rd(3'd4, v); check("R5 empty read", v, 32'h0);
        idle(1);
        rd(3'd3, v); check("R5 underrun bit", v & 32'h8, 32'h8);
        rd(3'd2, v); check("R5 still empty", v, 32'h1);
    endtask

    task automatic t_marks();
        logic [DW-1:0] v;
        wr(3'd1, (32'd3 << 16) | 32'd1);
        wr(3'd3, 32'hF);
        idle(2);
        check("R8 tx at empty", {31'b0, irq_tx_ready}, 32'h1);
        check("R7 rx at empty", {31'b0, irq_rx_ready}, 32'h0);
        for (int i = 0; i < 3; i++) wr(3'd4, 32'h300 + i);
        wr(3'd3, 32'hF);
        idle(2);
        check("R7 rx at count=mark", {31'b0, irq_rx_ready}, 32'h0);
        check("R8 tx above mark", {31'b0, irq_tx_ready}, 32'h0);
        wr(3'd4, 32'h303);
        idle(2);
        check("R7 rx above mark", {31'b0, irq_rx_ready}, 32'h1);
        wr(3'd3, 32'h1);
        idle(1);
        check("R9 clear while held", {31'b0, irq_rx_ready}, 32'h1);
        rd(3'd4, v);
        idle(1);
        check("R9 latched after drop", {31'b0, irq_rx_ready}, 32'h1);
        wr(3'd3, 32'h1);
        idle(1);
        check("R9 cleared", {31'b0, irq_rx_ready}, 32'h0);
    endtask

    task automatic t_flush();
        logic [DW-1:0] v;
        wr(3'd4, 32'h55);
        @(negedge clk); reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h1;
        @(negedge clk); reg_wr = 0; #1 check("R6 flag set", reg_rdata, 32'h1);
        @(negedge clk); #1 check("R6 flag cleared", reg_rdata, 32'h0);
        rd(3'd2, v); check("R6 emptied", v, 32'h1);
    endtask

    task automatic t_thresh();
        logic [DW-1:0] v;
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R10 fields", v, 32'h70FF_00FF);
        wr(3'd1, 32'h2005_0002);
        rd(3'd1, v); check("R10 pattern", v, 32'h2005_0002);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_order();
                t_full();
                t_marks();
                t_flush();
                t_thresh();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule